// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Core

This block encrypts 128-bit blocks with AES under a 128-bit cipher key. The ten cipher rounds are unrolled, and each round sits in its own register stage. A further stage in front of them performs the initial key addition. Every cycle the block can take in a new plaintext together with its own key, and the matching ciphertext comes out a fixed number of cycles later.

The round keys are expanded on the fly. Each stage derives the next round key from the key that arrived with its block, and the state and its key travel down the pipeline side by side. Consecutive blocks may therefore use unrelated keys with no setup time. The output cannot be stalled: a qualifying flag marks each valid result, and the consumer must accept it in that cycle.

Top module: `aes128_pipe`

## Requirements
- R1: With the 128-bit text and key read most-significant byte first, so that byte 0 is row 0 column 0, byte 1 is row 1 column 0 and byte 4 is row 0 column 1, `out_text` equals the AES-128 encryption of `in_text` under `in_key`. One example: key 000102030405060708090a0b0c0d0e0f with text 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: A block presented with `in_valid` high before clock edge k appears on `out_text` with `out_valid` high right after edge k+10, which is the eleventh rising edge counting edge k. `out_valid` is low in the cycles between.
- R3: A new block can be accepted on every cycle. Blocks presented on consecutive cycles leave on consecutive cycles, in the order they entered.
- R4: Each block is encrypted under the key presented with it, even when the key changes from one cycle to the next.
- R5: A cycle with `in_valid` low produces one cycle with `out_valid` low eleven cycles later. `out_text` does not change in a cycle where no block reaches the output.
- R6: Synchronous active-high `rst` drops every block in flight. `out_valid` is low during reset and in the first cycle after it, and no dropped block ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A block and its key are presented this cycle |
| in_key | input | 128 | Cipher key for the block presented |
| in_text | input | 128 | Plaintext block |
| out_valid | output | 1 | `out_text` carries a finished block |
| out_text | output | 128 | Ciphertext block |

## Verification
The bench aims at the ordering and timing faults that a known-answer test on its own can hide. A byte-order or row-shift direction error, or a wrong round constant in a later round, changes every ciphertext in the vector table. A final round that still mixes columns would fail all of them too. Streaming blocks whose keys change every cycle catches a design that shares one key register between stages, because it would encrypt later blocks under the wrong key. Gaps in the input catch a valid chain that is off by one stage, since the results would land one cycle early or late. A reset issued with blocks in flight catches valid flags that survive the flush.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

    localparam int BLK_W  = 128;
    localparam int NBYTES = BLK_W / 8;
    localparam int NCOL   = 4;
    localparam int NROW   = NBYTES / NCOL;
    localparam int ROUNDS = 10;
    localparam int LAT    = ROUNDS + 1;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic vld;
        blk_t st;
        blk_t rk;
    } stage_t;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254, followed by the affine map
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] res;
        logic [7:0] pw;
        logic [7:0] ex;
        res = 8'h01;
        pw  = x;
        ex  = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (ex[i]) res = gf_mul(res, pw);
            pw = gf_mul(pw, pw);
        end
        return res ^ {res[6:0], res[7]} ^ {res[5:0], res[7:6]}
                   ^ {res[4:0], res[7:5]} ^ {res[3:0], res[7:4]} ^ 8'h63;
    endfunction

    function automatic blk_t sub_bytes(input blk_t b);
        blk_t o;
        for (int i = 0; i < NBYTES; i++)
            o[BLK_W-1-8*i -: 8] = sbox(b[BLK_W-1-8*i -: 8]);
        return o;
    endfunction

    // row r takes its byte from column c+r
    function automatic blk_t shift_rows(input blk_t b);
        blk_t o;
        for (int c = 0; c < NCOL; c++)
            for (int r = 0; r < NROW; r++)
                o[BLK_W-1-8*(c*NROW+r) -: 8] = b[BLK_W-1-8*(((c+r)%NCOL)*NROW+r) -: 8];
        return o;
    endfunction

    function automatic blk_t mix_cols(input blk_t b);
        blk_t o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < NCOL; c++) begin
            a0 = b[BLK_W-1-8*(c*NROW+0) -: 8];
            a1 = b[BLK_W-1-8*(c*NROW+1) -: 8];
            a2 = b[BLK_W-1-8*(c*NROW+2) -: 8];
            a3 = b[BLK_W-1-8*(c*NROW+3) -: 8];
            o[BLK_W-1-8*(c*NROW+0) -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
            o[BLK_W-1-8*(c*NROW+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
            o[BLK_W-1-8*(c*NROW+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
            o[BLK_W-1-8*(c*NROW+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
        end
        return o;
    endfunction

    function automatic logic [7:0] rcon_of(input int rnd);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 1; i < rnd; i++) r = xtime(r);
        return r;
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes128_pkg::*;
#(
    parameter int RND = 1
) (
    input  blk_t cur_key,
    output blk_t nxt_key
);
    localparam logic [7:0] RCON = rcon_of(RND);

    logic [31:0] w0, w1, w2, w3, rot, tmix;
    logic [31:0] n0, n1, n2, n3;

    always_comb begin
        {w0, w1, w2, w3} = cur_key;
        rot  = {w3[23:0], w3[31:24]};
        tmix = {sbox(rot[31:24]) ^ RCON, sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])};
        n0   = w0 ^ tmix;
        n1   = w1 ^ n0;
        n2   = w2 ^ n1;
        n3   = w3 ^ n2;
        nxt_key = {n0, n1, n2, n3};
    end
endmodule

// File: rtl/aes_pre_stage.sv
module aes_pre_stage
    import aes128_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_vld,
    input  blk_t   in_text,
    input  blk_t   in_key,
    output stage_t out_stg
);
    stage_t stg_d, stg_q;

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = in_vld;
        if (in_vld) begin
            stg_d.st = in_text ^ in_key;
            stg_d.rk = in_key;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign out_stg = stg_q;
endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
    import aes128_pkg::*;
#(
    parameter int RND = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t in_stg,
    output stage_t out_stg
);
    localparam bit LAST = (RND == ROUNDS);

    stage_t stg_d, stg_q;
    blk_t   rk_new;
    blk_t   shifted;
    blk_t   mixed;

    aes_key_step #(.RND(RND)) u_key (
        .cur_key (in_stg.rk),
        .nxt_key (rk_new)
    );

    assign shifted = shift_rows(sub_bytes(in_stg.st));

    generate
        if (LAST) begin : g_final
            assign mixed = shifted;
        end else begin : g_mid
            assign mixed = mix_cols(shifted);
        end
    endgenerate

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = in_stg.vld;
        if (in_stg.vld) begin
            stg_d.st = mixed ^ rk_new;
            stg_d.rk = rk_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign out_stg = stg_q;
endmodule

// File: rtl/aes128_pipe.sv
module aes128_pipe
    import aes128_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] in_key,
    input  logic [127:0] in_text,
    output logic         out_valid,
    output logic [127:0] out_text
);
    stage_t stg [0:ROUNDS];
    logic   stg_v [0:ROUNDS];

    aes_pre_stage u_pre (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_text (in_text),
        .in_key  (in_key),
        .out_stg (stg[0])
    );

    generate
        for (genvar k = 1; k <= ROUNDS; k++) begin : g_rnd
            aes_round_stage #(.RND(k)) u_rnd (
                .clk     (clk),
                .rst     (rst),
                .in_stg  (stg[k-1]),
                .out_stg (stg[k])
            );
        end
        for (genvar k = 0; k <= ROUNDS; k++) begin : g_v
            assign stg_v[k] = stg[k].vld;
        end
    endgenerate

    assign out_valid = stg[ROUNDS].vld;
    assign out_text  = stg[ROUNDS].st;
endmodule

// File: rtl/aes128_pipe_chk.sv
module aes128_pipe_chk
    import aes128_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [127:0] out_text,
    input logic         s0_valid
);
    logic [LAT-1:0] ref_v;

    always_ff @(posedge clk) begin
        if (rst) ref_v <= '0;
        else     ref_v <= {ref_v[LAT-2:0], in_valid};
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == ref_v[LAT-1]);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_v[LAT-2] |=> $stable(out_text));

    // R6
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R3
    entry_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s0_valid == $past(in_valid)));
endmodule

bind aes128_pipe aes128_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_text  (out_text),
    .s0_valid  (stg_v[0])
);

// File: tb/tb_aes128_pipe.sv
module tb_aes128_pipe;
    localparam int NV  = 5;
    localparam int LAT = 11;

    // key, plaintext, ciphertext
    localparam logic [383:0] VEC [NV] = '{
        {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32},
        {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a, 128'h3ad77bb40d7a3660a89ecaf32466ef97},
        {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hae2d8a571e03ac9c9eb76fac45af8e51, 128'hf5d3d58503b9699de785895a96fdbaaf}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_key = '0;
    logic [127:0] in_text = '0;
    logic         out_valid;
    logic [127:0] out_text;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    aes128_pipe dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_key    (in_key),
        .in_text   (in_text),
        .out_valid (out_valid),
        .out_text  (out_text)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one block alone; outputs sampled at falling edges
    task automatic single(input int i);
        bit early;
        early = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_key   = VEC[i][383:256];
        in_text  = VEC[i][255:128];
        for (int n = 1; n <= LAT; n++) begin
            @(negedge clk);
            if (n == 1) in_valid = 1'b0;
            if (n < LAT && out_valid) early = 1'b1;
        end
        chk(!early, "R2 no early valid", {127'd0, early}, 128'd0);
        chk(out_valid, "R2 valid at latency", {127'd0, out_valid}, 128'd1);
        chk(out_text == VEC[i][127:0], "R1 ciphertext", out_text, VEC[i][127:0]);
        @(negedge clk);
        chk(!out_valid, "R2 single cycle valid", {127'd0, out_valid}, 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(!out_valid, "R6 valid low in reset", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R6 valid low after reset", {127'd0, out_valid}, 128'd0);

        // R1 R2: table of known answers, one block at a time
        for (int i = 0; i < NV; i++) single(i);

        // R3 R4: five blocks on consecutive cycles with changing keys
        for (int t = 0; t < NV + LAT + 2; t++) begin
            @(negedge clk);
            if (t >= LAT && t < LAT + NV) begin
                chk(out_valid, "R3 stream valid", {127'd0, out_valid}, 128'd1);
                chk(out_text == VEC[t-LAT][127:0], "R4 stream key per block", out_text, VEC[t-LAT][127:0]);
            end else begin
                chk(!out_valid, "R3 stream no extra valid", {127'd0, out_valid}, 128'd0);
            end
            if (t < NV) begin
                in_valid = 1'b1;
                in_key   = VEC[t][383:256];
                in_text  = VEC[t][255:128];
            end else begin
                in_valid = 1'b0;
            end
        end

        // R5: blocks at t=0,2,3 with a bubble at t=1, which also carries junk data
        begin
            logic [127:0] held;
            held = '0;
            for (int t = 0; t < LAT + 6; t++) begin
                @(negedge clk);
                if (t == LAT) begin
                    chk(out_valid && out_text == VEC[1][127:0], "R5 first of gap pattern", out_text, VEC[1][127:0]);
                    held = out_text;
                end else if (t == LAT + 1) begin
                    chk(!out_valid, "R5 bubble gives low valid", {127'd0, out_valid}, 128'd0);
                    chk(out_text == held, "R5 text held in bubble", out_text, held);
                end else if (t == LAT + 2) begin
                    chk(out_valid && out_text == VEC[3][127:0], "R5 after bubble", out_text, VEC[3][127:0]);
                end else if (t == LAT + 3) begin
                    chk(out_valid && out_text == VEC[0][127:0], "R5 last of gap pattern", out_text, VEC[0][127:0]);
                end else if (t > LAT + 3 || t < LAT) begin
                    chk(!out_valid, "R5 idle low", {127'd0, out_valid}, 128'd0);
                end
                in_valid = (t == 0 || t == 2 || t == 3);
                in_key   = (t == 0) ? VEC[1][383:256] : (t == 2) ? VEC[3][383:256] : VEC[0][383:256];
                in_text  = (t == 0) ? VEC[1][255:128] : (t == 2) ? VEC[3][255:128] :
                           (t == 3) ? VEC[0][255:128] : 128'hdeadbeef;
            end
        end

        // R6: reset with blocks in flight, none must emerge
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_key   = VEC[t][383:256];
            in_text  = VEC[t][255:128];
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int t = 0; t < LAT + 4; t++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            chk(!seen, "R6 flushed blocks never appear", {127'd0, seen}, 128'd0);
        end

        // R1 after reset: pipeline still works
        single(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule